// File: doc/BRIEF.md
# Asynchronous Static RAM Byte-Lane Controller

This block sits between a clocked host and an asynchronous static RAM of 128K words by 16 bits. The host hands it one word request at a time: read or write, a 17-bit word address, 16 bits of write data and a 2-bit byte mask. The controller turns each request into a cycle on the memory pins and meets every minimum pulse, setup and access time by counting clocks. It reports completion with a one-cycle done pulse and, for reads, a registered data word.

Every timing minimum is a parameter in nanoseconds, next to a clock-period parameter. Each minimum is rounded up to whole clocks when the design is built. A cycle always runs through the same phases: setup (address and byte enables presented, chip selected), strobe (write enable or output enable held low for the computed count), recover (strobes released, bus released), and then back to idle. The write window is bounded by chip select and write enable together. The address only moves while the chip is deselected. Output enable is never low while the controller drives the data bus.

With the default 4 ns clock, a write is busy for 18 cycles: 1 setup, 14 strobe and 3 recover. A read is busy for 19 cycles: 1 setup, 17 strobe and 1 recover.

Top module: `async_sram_ctrl`

## Requirements
- R1: After reset, ready is 1, done is 0, read data is 0, the bus drive-enable is 0, and all five active-low memory controls (chip enable, output enable, write enable, lower and upper byte enables) are 1.
- R2: A request is accepted only on a clock edge where the request input and ready are both 1 and the byte mask is not 2'b00. A mask of 2'b00 is ignored: ready stays 1, chip enable stays high, done never pulses and memory contents stay unchanged.
- R3: For a write accepted at edge k, chip enable is low for cycles 1 to 15 after k. Write enable is low for exactly 14 cycles (cycles 2 to 15) and only while chip enable is low. The window ends with both strobes rising at the same edge.
- R4: Mask bit 0 selects the lower byte enable (data bits 7:0) and mask bit 1 selects the upper byte enable (data bits 15:8). An enabled lane's byte enable is low exactly while chip enable is low, and a disabled lane's byte enable stays high.
- R5: While chip enable and write enable are both low, the memory address does not change. The address presented equals the request address throughout the cycle.
- R6: The drive-enable is 1 exactly in the cycles where write enable is low, with the write data on the output bus. Output enable is never low while the drive-enable is 1, and output enable and write enable are never low together.
- R7: For a read accepted at edge k, output enable is low for exactly 17 cycles (cycles 2 to 18) with write enable high. The bus is sampled at the end of cycle 18, and read data appears in cycle 19. Lanes whose mask bit is 0 read as zero.
- R8: Done is 1 for exactly one cycle, in cycle 16 for a write and cycle 19 for a read. Ready is 0 from cycle 1 and returns to 1 in cycle 19 for a write and cycle 20 for a read. These counts come from rounding each minimum up to whole clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Word address |
| reqWData | input | 16 | Write data |
| reqMask | input | 2 | Byte mask, bit 0 lower lane, bit 1 upper lane |
| ready | output | 1 | Controller idle, request may be accepted |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Captured read word |
| memAddr | output | 17 | Memory address |
| memCeN | output | 1 | Chip enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memLbN | output | 1 | Lower byte enable, active low |
| memUbN | output | 1 | Upper byte enable, active low |
| memDqOut | output | 16 | Data driven toward the memory |
| memDqIn | input | 16 | Data returned by the memory |
| memDqOe | output | 1 | Drive-enable for memDqOut |

## Verification
Each result is due a fixed number of cycles after the accept edge:
- write enable falls in cycle 2, done comes in cycle 16 and ready returns in cycle 19;
- output enable falls in cycle 2, read data and done come in cycle 19 and ready returns in cycle 20.

The bench drives and samples on the falling clock edge. After each accept it numbers every following cycle and records the first and last cycle of each strobe and the cycle of the done pulse. It compares these indices and the read word on the done cycle against these counts, which it works out from the timing minimums.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_STROBE  = 2'd2,
    ST_RECOVER = 2'd3
  } phase_t;

  // control -> datapath strobes
  typedef struct packed {
    logic load;     // latch a new request
    logic select;   // chip selected, byte enables live
    logic drive;    // drive write data onto the bus
    logic capture;  // sample the read bus
  } strobe_t;

  function automatic int clkCount(input int ns, input int periodNs);
    return (ns + periodNs - 1) / periodNs;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_NS  = 4,
  parameter int T_WC_NS = 70,
  parameter int T_WP_NS = 50,
  parameter int T_DW_NS = 30,
  parameter int T_CW_NS = 60,
  parameter int T_AS_NS = 0,
  parameter int T_WR_NS = 0,
  parameter int T_AA_NS = 70,
  parameter int T_OE_NS = 40,
  parameter int T_RC_NS = 70
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [LANES-1:0] reqMask,
  output logic             ready,
  output logic             done,
  output logic             ceN,
  output logic             oeN,
  output logic             weN,
  output strobe_t          strb
);

  localparam int SETUP_C = imax(1, clkCount(T_AS_NS, CLK_NS));
  localparam int WR_STB  = imax(imax(clkCount(T_WP_NS, CLK_NS), clkCount(T_DW_NS, CLK_NS)),
                                imax(1, clkCount(T_CW_NS, CLK_NS) - SETUP_C));
  localparam int WR_REC  = imax(imax(1, clkCount(T_WR_NS, CLK_NS)),
                                clkCount(T_WC_NS, CLK_NS) - SETUP_C - WR_STB);
  localparam int RD_STB  = imax(imax(1, clkCount(T_AA_NS, CLK_NS) - SETUP_C),
                                clkCount(T_OE_NS, CLK_NS));
  localparam int RD_REC  = imax(1, clkCount(T_RC_NS, CLK_NS) - SETUP_C - RD_STB);
  localparam int MAX_C   = imax(imax(SETUP_C, WR_STB), imax(imax(WR_REC, RD_STB), RD_REC));
  localparam int CNT_W   = $clog2(MAX_C) + 1;

  phase_t           state;
  logic [CNT_W-1:0] cnt;
  logic             isWr;
  logic             accept;
  logic             lastCyc;

  assign accept  = reqValid && (state == ST_IDLE) && (|reqMask);
  assign lastCyc = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      isWr  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= (state == ST_STROBE) && lastCyc;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state <= ST_SETUP;
            isWr  <= reqWrite;
            cnt   <= CNT_W'(SETUP_C - 1);
          end
        end
        ST_SETUP: begin
          if (lastCyc) begin
            state <= ST_STROBE;
            cnt   <= isWr ? CNT_W'(WR_STB - 1) : CNT_W'(RD_STB - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_STROBE: begin
          if (lastCyc) begin
            state <= ST_RECOVER;
            cnt   <= isWr ? CNT_W'(WR_REC - 1) : CNT_W'(RD_REC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (lastCyc) state <= ST_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
      endcase
    end
  end

  // strobes are decoded from the registered phase only
  assign ready = (state == ST_IDLE);
  assign ceN   = !((state == ST_SETUP) || (state == ST_STROBE));
  assign weN   = !((state == ST_STROBE) && isWr);
  assign oeN   = !((state == ST_STROBE) && !isWr);

  assign strb.load    = accept;
  assign strb.select  = (state == ST_SETUP) || (state == ST_STROBE);
  assign strb.drive   = (state == ST_STROBE) && isWr;
  assign strb.capture = (state == ST_STROBE) && !isWr && lastCyc;

  // R6
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!weN && !oeN));

  // R3
  we_in_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> !ceN);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (ceN && weN && oeN));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> (int'(cnt) < MAX_C));

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] dqIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic [LANES-1:0]  beN,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  maskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      maskQ <= '0;
    end else if (strb.load) begin
      addrQ <= reqAddr;
      dataQ <= reqWData;
      maskQ <= reqMask;
    end
  end

  assign addrOut = addrQ;
  assign dqOut   = dataQ;
  assign dqOe    = strb.drive;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign beN[g] = !(strb.select && maskQ[g]);

    always_ff @(posedge clk) begin
      if (!rstN)             rdData[g*8 +: 8] <= 8'h00;
      else if (strb.capture) rdData[g*8 +: 8] <= maskQ[g] ? dqIn[g*8 +: 8] : 8'h00;
    end
  end

  // R7
  capture_read_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> !strb.drive);

  // R5
  load_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> !strb.select);

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int CLK_NS  = 4,
  parameter int T_WC_NS = 70,
  parameter int T_WP_NS = 50,
  parameter int T_DW_NS = 30,
  parameter int T_CW_NS = 60,
  parameter int T_AS_NS = 0,
  parameter int T_WR_NS = 0,
  parameter int T_AA_NS = 70,
  parameter int T_OE_NS = 40,
  parameter int T_RC_NS = 70
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqWData,
  input  logic [1:0]        reqMask,
  output logic              ready,
  output logic              done,
  output logic [15:0]       rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memLbN,
  output logic              memUbN,
  output logic [15:0]       memDqOut,
  input  logic [15:0]       memDqIn,
  output logic              memDqOe
);

  strobe_t          strb;
  logic [LANES-1:0] beN;

  sram_ctrl_fsm #(
    .CLK_NS(CLK_NS), .T_WC_NS(T_WC_NS), .T_WP_NS(T_WP_NS), .T_DW_NS(T_DW_NS),
    .T_CW_NS(T_CW_NS), .T_AS_NS(T_AS_NS), .T_WR_NS(T_WR_NS), .T_AA_NS(T_AA_NS),
    .T_OE_NS(T_OE_NS), .T_RC_NS(T_RC_NS)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqMask(reqMask), .ready(ready), .done(done),
    .ceN(memCeN), .oeN(memOeN), .weN(memWeN), .strb(strb)
  );

  sram_ctrl_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqWData(reqWData), .reqMask(reqMask), .dqIn(memDqIn),
    .addrOut(memAddr), .dqOut(memDqOut), .dqOe(memDqOe),
    .beN(beN), .rdData(rdData)
  );

  assign memLbN = beN[0];
  assign memUbN = beN[1];

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && !memWeN) |-> $stable(memAddr));

  // R6
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (memOeN && !memWeN));

  // R4
  lane_in_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memLbN || !memUbN) |-> !memCeN);

endmodule

// File: tb/async_sram_ctrl_bench.sv
module async_sram_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite;
  logic [16:0] reqAddr;
  logic [15:0] reqWData;
  logic [1:0]  reqMask;
  logic        ready, done;
  logic [15:0] rdData;
  logic [16:0] memAddr;
  logic        memCeN, memOeN, memWeN, memLbN, memUbN, memDqOe;
  logic [15:0] memDqOut, memDqIn;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  async_sram_ctrl u_async_sram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWData(reqWData), .reqMask(reqMask),
    .ready(ready), .done(done), .rdData(rdData), .memAddr(memAddr),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN), .memLbN(memLbN),
    .memUbN(memUbN), .memDqOut(memDqOut), .memDqIn(memDqIn), .memDqOe(memDqOe)
  );

  // small memory model, indexed by the low address byte
  logic [15:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = 16'h0000;

  always @(posedge clk) begin
    if (!memCeN && !memWeN) begin
      if (!memLbN) mem[memAddr[7:0]][7:0]  = memDqOut[7:0];
      if (!memUbN) mem[memAddr[7:0]][15:8] = memDqOut[15:8];
    end
  end

  always_comb begin
    memDqIn = 16'hDEAD;
    if (!memCeN && !memOeN && memWeN) begin
      if (!memLbN) memDqIn[7:0]  = mem[memAddr[7:0]][7:0];
      if (!memUbN) memDqIn[15:8] = mem[memAddr[7:0]][15:8];
    end
  end

  // expected timing from the minimums at a 4 ns clock
  localparam int SETUP_C = 1;
  localparam int WR_STB  = 14;  // max(ceil(50/4), ceil(30/4), ceil(60/4)-1)
  localparam int WR_REC  = 3;   // ceil(70/4) - 1 - 14
  localparam int RD_STB  = 17;  // max(ceil(70/4)-1, ceil(40/4))
  localparam int RD_REC  = 1;

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // vector fields: [51] write, [50:34] addr, [33:18] data, [17:16] mask, [15:0] expected read
  localparam int NV = 8;
  localparam logic [51:0] VEC [NV] = '{
    {1'b1, 17'h00010, 16'hA55A, 2'b11, 16'h0000},
    {1'b1, 17'h00020, 16'h1234, 2'b11, 16'h0000},
    {1'b1, 17'h00020, 16'hFFEE, 2'b01, 16'h0000},
    {1'b1, 17'h00010, 16'h77CC, 2'b10, 16'h0000},
    {1'b0, 17'h00010, 16'h0000, 2'b11, 16'h775A},
    {1'b0, 17'h00020, 16'h0000, 2'b11, 16'h12EE},
    {1'b0, 17'h00020, 16'h0000, 2'b10, 16'h1200},
    {1'b0, 17'h00010, 16'h0000, 2'b01, 16'h005A}
  };

  task automatic runOp(input bit wr, input logic [16:0] a, input logic [15:0] d,
                       input logic [1:0] m, input logic [15:0] expRd);
    int ceLow = 0, weLow = 0, oeLow = 0, lbLow = 0, ubLow = 0;
    int weFirst = 0, oeFirst = 0, doneIdx = 0, doneCnt = 0, readyIdx = 0;
    int badDrive = 0, badAddr = 0, badLane = 0;
    logic [15:0] rdAtDone = 16'h0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWData = d; reqMask = m;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 1; i < 40; i++) begin
      if (ready) begin readyIdx = i; break; end
      if (!memCeN) begin
        ceLow++;
        if (memAddr != a) badAddr++;
      end
      if (!memWeN) begin weLow++; if (weFirst == 0) weFirst = i; end
      if (!memOeN) begin oeLow++; if (oeFirst == 0) oeFirst = i; end
      if (!memLbN) lbLow++;
      if (!memUbN) ubLow++;
      if ((!memLbN || !memUbN) && memCeN) badLane++;
      if (memDqOe != !memWeN) badDrive++;
      if (memDqOe && memDqOut != d) badDrive++;
      if (done) begin doneCnt++; doneIdx = i; rdAtDone = rdData; end
      @(negedge clk);
    end
    if (wr) begin
      check("R3 ce low cycles", ceLow == SETUP_C + WR_STB, ceLow, SETUP_C + WR_STB);
      check("R3 we low cycles", weLow == WR_STB, weLow, WR_STB);
      check("R3 we first cycle", weFirst == 2, weFirst, 2);
      check("R6 oe stays high in write", oeLow == 0, oeLow, 0);
      check("R6 drive matches we", badDrive == 0, badDrive, 0);
      check("R8 write done cycle", doneIdx == SETUP_C + WR_STB + 1, doneIdx, SETUP_C + WR_STB + 1);
      check("R8 write ready return", readyIdx == SETUP_C + WR_STB + WR_REC + 1,
            readyIdx, SETUP_C + WR_STB + WR_REC + 1);
    end else begin
      check("R7 oe low cycles", oeLow == RD_STB, oeLow, RD_STB);
      check("R7 oe first cycle", oeFirst == 2, oeFirst, 2);
      check("R7 we stays high in read", weLow == 0, weLow, 0);
      check("R7 read data", rdAtDone == expRd, rdAtDone, expRd);
      check("R8 read done cycle", doneIdx == SETUP_C + RD_STB + 1, doneIdx, SETUP_C + RD_STB + 1);
      check("R8 read ready return", readyIdx == SETUP_C + RD_STB + RD_REC + 1,
            readyIdx, SETUP_C + RD_STB + RD_REC + 1);
    end
    check("R8 single done pulse", doneCnt == 1, doneCnt, 1);
    check("R5 address held", badAddr == 0, badAddr, 0);
    check("R4 lower lane cycles", lbLow == (m[0] ? ceLow : 0), lbLow, m[0] ? ceLow : 0);
    check("R4 upper lane cycles", ubLow == (m[1] ? ceLow : 0), ubLow, m[1] ? ceLow : 0);
    check("R4 lanes only while selected", badLane == 0, badLane, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0;
    reqAddr = '0; reqWData = '0; reqMask = 2'b00;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", ready == 1'b1, ready, 1);
    check("R1 done", done == 1'b0, done, 0);
    check("R1 rdData", rdData == 16'h0, rdData, 0);
    check("R1 drive off", memDqOe == 1'b0, memDqOe, 0);
    check("R1 controls high", {memCeN, memOeN, memWeN, memLbN, memUbN} == 5'b11111,
          {memCeN, memOeN, memWeN, memLbN, memUbN}, 5'b11111);

    for (int v = 0; v < NV; v++)
      runOp(VEC[v][51], VEC[v][50:34], VEC[v][33:18], VEC[v][17:16], VEC[v][15:0]);

    // R2: empty mask write is ignored
    begin
      int ceSeen = 0, doneSeen = 0, notReady = 0;
      @(negedge clk);
      reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 17'h10; reqWData = 16'h0000; reqMask = 2'b00;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (!memCeN) ceSeen++;
        if (done) doneSeen++;
        if (!ready) notReady++;
      end
      reqValid = 1'b0;
      check("R2 no select on empty mask", ceSeen == 0, ceSeen, 0);
      check("R2 no done on empty mask", doneSeen == 0, doneSeen, 0);
      check("R2 ready held on empty mask", notReady == 0, notReady, 0);
    end
    // R2: memory unchanged after ignored write
    runOp(1'b0, 17'h10, 16'h0, 2'b11, 16'h775A);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule